// File: doc/BRIEF.md
# Pattern-Triggered Serial Frame Receiver

This block receives a serial bit stream one bit per bit-clock enable strobe and packs the bits into words for a host. A frame can begin in one of two ways. In continuous mode it begins at once when the receiver is enabled and starts again right after each frame. In pattern mode it begins when the most recent bits received match a programmed start pattern. Each frame has an optional lead-in of delay bits, then a fixed number of words, each of a programmed length.

In pattern mode a stop mode picks what happens after the frame. The receiver can wait for the start pattern again. It can also keep receiving frames back to back until a second pattern, the end pattern, appears in the same sliding window. The first bits of every frame are also collected into a sync register. Ready, overrun and pattern flags tell the host when to read the data and the status.

Top module: `patsync_rx`

## Requirements
- R1: `sdi` is sampled only in cycles where `bit_en` is high. Its value in other cycles has no effect.
- R2: In pattern mode (`start_mode`=1), a frame starts on the strobe where the last S = `sync_len`+1 received bits equal the low S bits of `cmp0_pat`. The first of those bits is compared with bit S-1 of the pattern. A match needs at least S strobes since the receiver was enabled. The match sets `cmp0_flag`.
- R3: Bit index 0 is the first strobe after the start event. The first `start_dly` bits are not data. Data begins at bit index `start_dly`.
- R4: A word holds `word_len`+1 bits, from 1 to 32. A frame holds `word_cnt`+1 words, from 1 to 16, sent back to back.
- R5: `hold_word` is right-aligned and its unused upper bits are zero. With `msb_first`=1 the first bit of a word lands in bit `word_len`. With `msb_first`=0 it lands in bit 0.
- R6: Loading a word sets `ready`. A `rd_data` pulse clears `ready`, unless a word is loaded in the same cycle.
- R7: `overrun` is set when a word is loaded while `ready` is high and `rd_data` is low in that cycle. A `rd_status` pulse clears it, unless a new overrun occurs in the same cycle.
- R8: Bits 0 to S-1 of each frame are shifted into `sync_word`, with the first bit most significant and the upper bits zero. These bits are also data bits when the data window overlaps them.
- R9: In pattern mode with `stop_mode`=0, no word is loaded after a frame ends until a new start-pattern match occurs.
- R10: In pattern mode with `stop_mode`=1, each new frame begins on the strobe after the previous frame ends. This continues until the window matches the low S bits of `cmp1_pat`. That match sets `cmp1_flag`, drops the partial word, including a word that would complete on that strobe, and halts reception.
- R11: `cmp0_flag` and `cmp1_flag` stay high until a `rd_status` pulse clears them.
- R12: In continuous mode (`start_mode`=0), a frame starts one cycle after `en` goes high. A new frame starts on the strobe after each frame ends.
- R13: Driving `en` low aborts any frame in progress and empties the match window. The next match then needs S fresh bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable |
| bit_en | input | 1 | Bit strobe, one bit per high cycle |
| sdi | input | 1 | Serial data in |
| cmp0_pat | input | 16 | Start pattern, low S bits used |
| cmp1_pat | input | 16 | End pattern, low S bits used |
| sync_len | input | 4 | Sync/pattern length minus one |
| start_dly | input | 8 | Delay bits before data |
| word_len | input | 5 | Word length minus one |
| word_cnt | input | 4 | Words per frame minus one |
| msb_first | input | 1 | 1: first bit is the MSB |
| stop_mode | input | 1 | 1: run until end pattern |
| start_mode | input | 1 | 0: continuous, 1: pattern start |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| hold_word | output | 32 | Received word |
| sync_word | output | 16 | Sync bits of the current or last frame |
| ready | output | 1 | Unread word present |
| overrun | output | 1 | Word lost before being read |
| cmp0_flag | output | 1 | Start pattern seen |
| cmp1_flag | output | 1 | End pattern seen |

## Verification
A word load can fall in the same cycle as a host read. Two collisions matter. First, the last bit of a word is strobed together with `rd_data` while `ready` is high. This must leave `ready` set with no overrun. Second, a load that overruns is strobed together with `rd_status`, and the new overrun must win over the clear. The end-pattern match is also made to coincide with the last bit of a word, and the check is that no word is loaded.

// File: rtl/patsync_pkg.sv
package patsync_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

    typedef enum logic {
        START_CONT    = 1'b0,
        START_PATTERN = 1'b1
    } start_mode_e;

endpackage

// File: rtl/patsync_window.sv
module patsync_window #(
    parameter  int PAT_W  = 16,
    localparam int SLEN_W = $clog2(PAT_W),
    localparam int FILL_W = $clog2(PAT_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  shift,
    input  logic                  bit_i,
    input  logic [SLEN_W-1:0]     len,
    input  logic [1:0][PAT_W-1:0] pats,
    output logic [1:0]            hits
);

    logic [PAT_W-1:0]  win_q,  win_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic [PAT_W-1:0]  mask;
    logic              full;

    always_comb begin
        win_d  = win_q;
        fill_d = fill_q;
        if (clr) begin
            win_d  = '0;
            fill_d = '0;
        end else if (shift) begin
            win_d = {win_q[PAT_W-2:0], bit_i};
            if (fill_q != FILL_W'(PAT_W)) fill_d = fill_q + 1'b1;
        end
        for (int i = 0; i < PAT_W; i++) mask[i] = (i <= int'(len));
        full = (fill_d > FILL_W'(len));
    end

    for (genvar g = 0; g < 2; g++) begin : g_cmp
        assign hits[g] = shift && !clr && full &&
                         (((win_d ^ pats[g]) & mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else begin
            win_q  <= win_d;
            fill_q <= fill_d;
        end
    end

endmodule

// File: rtl/patsync_insert.sv
module patsync_insert #(
    parameter  int DATA_W = 32,
    localparam int LEN_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] base,
    input  logic              bit_i,
    input  logic [LEN_W-1:0]  pos,
    input  logic              msb_first,
    output logic [DATA_W-1:0] word_o
);

    always_comb begin
        if (msb_first) begin
            word_o = {base[DATA_W-2:0], bit_i};
        end else begin
            word_o = base;
            word_o[pos] = bit_i;
        end
    end

endmodule

// File: rtl/patsync_rx.sv
module patsync_rx
    import patsync_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int PAT_W  = 16,
    parameter  int DLY_W  = 8,
    parameter  int WCNT_W = 4,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int SLEN_W = $clog2(PAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_en,
    input  logic              sdi,
    input  logic [PAT_W-1:0]  cmp0_pat,
    input  logic [PAT_W-1:0]  cmp1_pat,
    input  logic [SLEN_W-1:0] sync_len,
    input  logic [DLY_W-1:0]  start_dly,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [WCNT_W-1:0] word_cnt,
    input  logic              msb_first,
    input  logic              stop_mode,
    input  logic              start_mode,
    input  logic              rd_status,
    input  logic              rd_data,
    output logic [DATA_W-1:0] hold_word,
    output logic [PAT_W-1:0]  sync_word,
    output logic              ready,
    output logic              overrun,
    output logic              cmp0_flag,
    output logic              cmp1_flag
);

    typedef struct packed {
        rx_state_e           st;
        logic [DLY_W-1:0]    dly;
        logic [SLEN_W:0]     scnt;
        logic [LEN_W-1:0]    bcnt;
        logic [WCNT_W-1:0]   widx;
        logic [DATA_W-1:0]   acc;
        logic [DATA_W-1:0]   hold;
        logic [PAT_W-1:0]    sync;
        logic                rdy;
        logic                ovr;
        logic                c0;
        logic                c1;
    } rx_regs_t;

    rx_regs_t          r_q, r_d;
    logic [1:0]        hits;
    logic [DATA_W-1:0] packed_word;
    logic [DATA_W-1:0] base_word;
    logic [SLEN_W:0]   sync_bits;
    logic              pattern_mode;
    logic              word_load;
    logic              frame_end;
    logic              start_go;
    logic              clr_cnt;
    logic              running;

    assign pattern_mode = (start_mode_e'(start_mode) == START_PATTERN);
    assign sync_bits    = {1'b0, sync_len} + 1'b1;
    assign base_word    = (r_q.bcnt == '0) ? '0 : r_q.acc;
    assign running      = (r_q.st == RX_RUN);

    patsync_window #(.PAT_W(PAT_W)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .shift (bit_en && en),
        .bit_i (sdi),
        .len   (sync_len),
        .pats  ({cmp1_pat, cmp0_pat}),
        .hits  (hits)
    );

    patsync_insert #(.DATA_W(DATA_W)) u_insert (
        .base      (base_word),
        .bit_i     (sdi),
        .pos       (r_q.bcnt),
        .msb_first (msb_first),
        .word_o    (packed_word)
    );

    always_comb begin
        r_d       = r_q;
        word_load = 1'b0;
        frame_end = 1'b0;
        start_go  = 1'b0;
        clr_cnt   = 1'b0;

        // host reads clear first; same-cycle events below win
        if (rd_data) r_d.rdy = 1'b0;
        if (rd_status) begin
            r_d.ovr = 1'b0;
            r_d.c0  = 1'b0;
            r_d.c1  = 1'b0;
        end

        if (!en) begin
            r_d.st  = RX_IDLE;
            clr_cnt = 1'b1;
        end else if (r_q.st == RX_IDLE) begin
            if (!pattern_mode) begin
                start_go = 1'b1;
            end else if (bit_en && hits[0]) begin
                start_go = 1'b1;
                r_d.c0   = 1'b1;
            end
        end else if (bit_en) begin
            if (pattern_mode && stop_mode && hits[1]) begin
                r_d.c1  = 1'b1;
                r_d.st  = RX_IDLE;
                clr_cnt = 1'b1;
            end else begin
                if (r_q.scnt < sync_bits) begin
                    r_d.sync = (r_q.scnt == '0) ? {{(PAT_W-1){1'b0}}, sdi}
                                                : {r_q.sync[PAT_W-2:0], sdi};
                    r_d.scnt = r_q.scnt + 1'b1;
                end
                if (r_q.dly < start_dly) begin
                    r_d.dly = r_q.dly + 1'b1;
                end else begin
                    r_d.acc = packed_word;
                    if (r_q.bcnt == word_len) begin
                        word_load = 1'b1;
                        r_d.bcnt  = '0;
                        if (r_q.widx == word_cnt) frame_end = 1'b1;
                        else                      r_d.widx  = r_q.widx + 1'b1;
                    end else begin
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end
                end
            end
        end

        if (start_go || frame_end) clr_cnt = 1'b1;
        if (start_go) r_d.st = RX_RUN;
        if (frame_end && pattern_mode && !stop_mode) r_d.st = RX_IDLE;

        if (clr_cnt) begin
            r_d.dly  = '0;
            r_d.scnt = '0;
            r_d.bcnt = '0;
            r_d.widx = '0;
        end

        if (word_load) begin
            r_d.hold = packed_word;
            r_d.rdy  = 1'b1;
            if (r_q.rdy && !rd_data) r_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold_word = r_q.hold;
    assign sync_word = r_q.sync;
    assign ready     = r_q.rdy;
    assign overrun   = r_q.ovr;
    assign cmp0_flag = r_q.c0;
    assign cmp1_flag = r_q.c1;

endmodule

// File: rtl/patsync_rx_chk.sv
module patsync_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic rd_data,
    input logic rd_status,
    input logic stop_mode,
    input logic word_load,
    input logic running,
    input logic ready,
    input logic overrun,
    input logic cmp1_flag
);

    AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |=> ready); // R6

    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !word_load) |=> !ready); // R6

    AST_OVERRUN_ON_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (word_load && ready && !rd_data) |=> overrun); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_status) |=> overrun); // R7

    AST_LOAD_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |-> running); // R4

    AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !running); // R13

    AST_END_PATTERN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp1_flag) |-> $past(stop_mode)); // R10

endmodule

bind patsync_rx patsync_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .stop_mode (stop_mode),
    .word_load (word_load),
    .running   (running),
    .ready     (ready),
    .overrun   (overrun),
    .cmp1_flag (cmp1_flag)
);

// File: tb/patsync_rx_tb.sv
`timescale 1ns/1ps
module patsync_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, bit_en = 1'b0, sdi = 1'b0;
    logic [15:0] cmp0_pat = '0, cmp1_pat = '0;
    logic [3:0]  sync_len = '0;
    logic [7:0]  start_dly = '0;
    logic [4:0]  word_len = '0;
    logic [3:0]  word_cnt = '0;
    logic        msb_first = 1'b1, stop_mode = 1'b0, start_mode = 1'b0;
    logic        rd_status = 1'b0, rd_data = 1'b0;
    logic [31:0] hold_word;
    logic [15:0] sync_word;
    logic        ready, overrun, cmp0_flag, cmp1_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic fbits [0:127];
    int   fn = 0;

    always #5 clk = ~clk;

    patsync_rx u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en), .sdi(sdi),
        .cmp0_pat(cmp0_pat), .cmp1_pat(cmp1_pat), .sync_len(sync_len),
        .start_dly(start_dly), .word_len(word_len), .word_cnt(word_cnt),
        .msb_first(msb_first), .stop_mode(stop_mode), .start_mode(start_mode),
        .rd_status(rd_status), .rd_data(rd_data), .hold_word(hold_word),
        .sync_word(sync_word), .ready(ready), .overrun(overrun),
        .cmp0_flag(cmp0_flag), .cmp1_flag(cmp1_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // one strobed bit, then an idle cycle with sdi inverted (R1)
    task automatic send_bit_x(input logic b, input logic rd, input logic st);
        @(negedge clk);
        sdi = b; bit_en = 1'b1; rd_data = rd; rd_status = st;
        @(negedge clk);
        bit_en = 1'b0; rd_data = 1'b0; rd_status = 1'b0; sdi = ~b;
        @(negedge clk);
        if (fn < 128) begin fbits[fn] = b; fn++; end
    endtask

    task automatic send_bit(input logic b);
        send_bit_x(b, 1'b0, 1'b0);
    endtask

    task automatic send_word(input logic [31:0] v, input int w, input logic msb);
        for (int i = 0; i < w; i++) send_bit(msb ? v[w-1-i] : v[i]);
    endtask

    task automatic pulse_rd;
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
    endtask

    task automatic pulse_st;
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); en = v;
        @(negedge clk);
    endtask

    function automatic logic [15:0] fold(input int s);
        logic [15:0] r = '0;
        for (int i = 0; i < s; i++) r = {r[14:0], fbits[i]};
        return r;
    endfunction

    function automatic logic [31:0] wmask(input int w);
        return 32'((64'd1 << w) - 1);
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        int lens [5] = '{0, 3, 7, 12, 31};
        int sls  [4] = '{0, 3, 7, 15};
        logic [31:0] v;
        logic [15:0] p;
        int s, w;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R6 reset ready", ready, 0);
        chk_eq("R7 reset overrun", overrun, 0);
        chk_eq("R11 reset flags", {cmp0_flag, cmp1_flag}, 0);
        chk_eq("R5 reset hold", hold_word, 0);

        // continuous mode sweep: length x order x delay
        start_mode = 1'b0; stop_mode = 1'b0; sync_len = 4'd3; word_cnt = 4'd1;
        for (int li = 0; li < 5; li++) begin
            for (int m = 0; m < 2; m++) begin
                for (int d = 0; d < 2; d++) begin
                    word_len = 5'(lens[li]); msb_first = m[0]; start_dly = 8'(2 * d);
                    w = lens[li] + 1;
                    set_en(1'b1);
                    fn = 0;
                    for (int j = 0; j < 2 * d; j++) send_bit(j[0]);
                    for (int k = 0; k < 2; k++) begin
                        v = (32'h9E3779B1 * 32'(li * 8 + m * 4 + d * 2 + k + 1)) & wmask(w);
                        send_word(v, w, msb_first);
                        chk_eq("R1/R4/R5/R12 word value", hold_word, v);
                        chk_eq("R6 ready after load", ready, 1);
                        if (k == 1 && fn >= 4)
                            chk_eq("R8/R3 sync capture", sync_word, fold(4));
                        pulse_rd;
                        chk_eq("R6 ready after read", ready, 0);
                    end
                    set_en(1'b0);
                end
            end
        end
        pulse_st;

        // pattern start, single frame per match
        start_mode = 1'b1; stop_mode = 1'b0; word_len = 5'd7; word_cnt = 4'd0; msb_first = 1'b1;
        for (int si = 0; si < 4; si++) begin
            for (int d = 0; d < 2; d++) begin
                s = sls[si] + 1;
                if (d == 0 && s > 9) continue;
                sync_len = 4'(sls[si]);
                start_dly = (d == 0) ? 8'd1 : 8'(s);
                p = 16'hA5C3 ^ (16'h1111 * 16'(si)) ^ 16'(d);
                cmp0_pat = p;
                set_en(1'b1);
                pulse_st;
                for (int i = 0; i < s; i++) send_bit(p[s-1-i]);
                chk_eq("R2 start pattern flag", cmp0_flag, 1);
                fn = 0;
                for (int j = 0; j < int'(start_dly); j++) send_bit(~j[0]);
                v = 32'(8'h3C ^ 8'(si * 37 + d * 5));
                send_word(v, 8, 1'b1);
                chk_eq("R3 delayed word", hold_word, v);
                chk_eq("R8 sync bits", sync_word, fold(s));
                chk_eq("R11 flag held", cmp0_flag, 1);
                pulse_rd;
                pulse_st;
                chk_eq("R11 flag cleared", cmp0_flag, 0);
                for (int j = 0; j < 8; j++) send_bit(~p[0]);
                chk_eq("R9 halted after frame", ready, 0);
                chk_eq("R9 hold kept", hold_word, v);
                set_en(1'b0);
            end
        end

        // run until end pattern
        sync_len = 4'd3; start_dly = 8'd0; word_len = 5'd3; word_cnt = 4'd0;
        stop_mode = 1'b1; cmp0_pat = 16'h000B; cmp1_pat = 16'hFFF0;
        set_en(1'b1);
        pulse_st;
        send_word(32'hB, 4, 1'b1);
        chk_eq("R2 stream start", cmp0_flag, 1);
        send_word(32'hA, 4, 1'b1);
        chk_eq("R10 first frame", hold_word, 32'hA);
        pulse_rd;
        send_word(32'h3, 4, 1'b1);
        chk_eq("R10 second frame", hold_word, 32'h3);
        pulse_rd;
        send_word(32'h0, 4, 1'b1);
        chk_eq("R10 end pattern flag", cmp1_flag, 1);
        chk_eq("R10 colliding word dropped", ready, 0);
        send_word(32'hE, 4, 1'b1);
        chk_eq("R10 halted", ready, 0);
        chk_eq("R11 end flag held", cmp1_flag, 1);
        pulse_st;
        chk_eq("R11 end flag cleared", cmp1_flag, 0);
        set_en(1'b0);

        // overrun and same-cycle collisions
        start_mode = 1'b0; stop_mode = 1'b0;
        set_en(1'b1);
        send_word(32'h5, 4, 1'b1);
        chk_eq("R7 no overrun first", overrun, 0);
        send_word(32'h9, 4, 1'b1);
        chk_eq("R7 overrun set", overrun, 1);
        chk_eq("R7 newest word kept", hold_word, 32'h9);
        pulse_st;
        chk_eq("R7 overrun cleared", overrun, 0);
        pulse_rd;
        send_word(32'hE, 4, 1'b1);
        send_word(32'h3, 3, 1'b1);
        send_bit_x(1'b0, 1'b1, 1'b0);
        chk_eq("R6 load with read keeps ready", ready, 1);
        chk_eq("R7 load with read no overrun", overrun, 0);
        chk_eq("R6 collided word", hold_word, 32'h6);
        send_word(32'h0, 3, 1'b1);
        send_bit_x(1'b1, 1'b0, 1'b1);
        chk_eq("R7 overrun beats status clear", overrun, 1);
        pulse_st;
        pulse_rd;
        set_en(1'b0);

        // disable aborts frame and empties window
        word_len = 5'd7;
        set_en(1'b1);
        send_word(32'hF, 4, 1'b1);
        set_en(1'b0);
        set_en(1'b1);
        send_word(32'h3C, 8, 1'b1);
        chk_eq("R13 partial word abandoned", hold_word, 32'h3C);
        pulse_rd;
        set_en(1'b0);
        start_mode = 1'b1; sync_len = 4'd3; cmp0_pat = 16'h0009;
        set_en(1'b1);
        pulse_st;
        send_word(32'h4, 3, 1'b1);
        set_en(1'b0);
        set_en(1'b1);
        send_bit(1'b1);
        chk_eq("R13 window emptied", cmp0_flag, 0);
        send_word(32'h1, 3, 1'b1);
        chk_eq("R2 match after refill", cmp0_flag, 1);
        set_en(1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule